// File: doc/BRIEF.md
# I2C Master Command Control Register

This block is the command and configuration register that software uses to drive an I2C master. Software writes one 32-bit word through a plain write port with per-byte lane strobes. The block holds the target address, the transfer direction, the addressing mode, a header-only read flag, a transfer byte count and two end-of-transfer mode bits. It presents each of these as a separate output to the bus engine. The whole word can also be read back at any time.

Four command bits request bus actions: START, STOP, NACK and PEC-byte. Software can only set them, by writing ones. Writing zeros does nothing. The bus engine clears them by pulsing event inputs. Any of the four clear events for a bit wins over a set in the same cycle, and a low peripheral enable acts as a clear for all four.

START is held by a two-state machine. `ST_IDLE` moves to `ST_PEND` when a set is written and no START clear is present in that cycle. `ST_PEND` returns to `ST_IDLE` on any START clear. While the machine is in `ST_PEND`, the address and transfer-shape fields are frozen. The two end-of-transfer mode bits and the command bits stay writable. A parameter removes the PEC-byte bit entirely for builds without SMBus support.

Top module: `i2c_cmd_ctrl_reg`

## Requirements
- R1: After reset, every bit of `rd_data` and every field output is 0.
- R2: Readback layout: bits 9:0 hold the target address, 10 the direction, 11 the 10-bit addressing mode, 12 the header-only read, 13 START, 14 STOP, 15 NACK, 23:16 the byte count, 24 RELOAD, 25 AUTOEND and 26 PEC-byte. Bits 31:27 always read 0.
- R3: A write changes only the bits in lanes whose strobe is 1. Lane 0 covers bits 7:0, lane 1 bits 15:8, lane 2 bits 23:16 and lane 3 bits 31:24.
- R4: Writing 1 to a command bit (13, 14, 15 or 26) sets it. Writing 0 to a command bit leaves it unchanged.
- R5: START clears on any of these: the address phase done, arbitration lost, timeout, or the address-flag clear strobe.
- R6: STOP clears when a stop condition is detected.
- R7: NACK clears when the NACK has been sent, when a stop is detected, or on an address match.
- R8: PEC-byte clears when the PEC byte has been sent, when a stop is detected, or on an address match.
- R9: While `periph_en` is 0, all four command bits are cleared and cannot be set.
- R10: When a clear event for a command bit arrives in the same cycle as a write that sets it, the bit ends up 0.
- R11: While START reads 1, writes to the address, direction, addressing-mode, header-only and byte-count fields are ignored. RELOAD, AUTOEND and the command bits still accept writes.
- R12: With `SMBUS_EN` = 0, bit 26 and `pec_req` always read 0.
- R13: A write or event sampled at a rising edge is visible on `rd_data` and on the field outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; 0 clears all command bits |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte lane strobes |
| ev_addr_done | input | 1 | Start and address phase complete |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_timeout | input | 1 | Bus timeout |
| ev_addr_clr | input | 1 | Address-flag clear strobe |
| ev_stop_det | input | 1 | Stop condition detected |
| ev_nack_sent | input | 1 | NACK transmitted |
| ev_addr_match | input | 1 | Own address matched |
| ev_pec_sent | input | 1 | PEC byte transferred |
| rd_data | output | 32 | Register readback |
| tgt_addr | output | 10 | Target address |
| dir_rd | output | 1 | Transfer direction, 1 = read |
| addr10 | output | 1 | 10-bit addressing mode |
| hdr_only | output | 1 | Header-only 10-bit read |
| nbytes | output | 8 | Byte count |
| reload | output | 1 | Byte-count reload mode |
| autoend | output | 1 | Automatic end mode |
| start_req | output | 1 | START command pending |
| stop_req | output | 1 | STOP command pending |
| nack_req | output | 1 | NACK command pending |
| pec_req | output | 1 | PEC-byte command pending |

## Verification
Every result of this block is due exactly one rising edge after the write or event that causes it. The readback and the field outputs are plain decodes of the same flops, so neither adds a cycle. The bench changes inputs on falling edges. It keeps a model word that it advances by one step for each rising edge, and it compares the readback and the field outputs at the next falling edge. The expected value therefore always refers to the single edge in between. A second instance built without SMBus support is compared against the same model with bit 26 forced to 0.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
    localparam int REG_W     = 32;
    localparam int LANES     = REG_W / 8;
    localparam int ADDR_W    = 10;
    localparam int CNT_W     = 8;
    localparam int POS_DIR   = ADDR_W;
    localparam int POS_A10   = POS_DIR + 1;
    localparam int POS_HDR   = POS_A10 + 1;
    localparam int POS_START = POS_HDR + 1;
    localparam int POS_STOP  = POS_START + 1;
    localparam int POS_NACK  = POS_STOP + 1;
    localparam int POS_CNT   = POS_NACK + 1;
    localparam int POS_RLD   = POS_CNT + CNT_W;
    localparam int POS_AEND  = POS_RLD + 1;
    localparam int POS_PEC   = POS_AEND + 1;
    localparam int USED_W    = POS_PEC + 1;
    localparam int NCMD      = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } start_st_e;

    typedef enum int {
        CMD_STOP = 0,
        CMD_NACK = 1,
        CMD_PEC  = 2
    } cmd_idx_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              dir;
        logic              a10;
        logic              hdr;
        logic [CNT_W-1:0]  cnt;
        logic              rld;
        logic              aend;
    } cfg_t;
endpackage

// File: rtl/i2c_cmd_w1s_bit.sv
module i2c_cmd_w1s_bit #(
    parameter bit PRESENT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    generate
        if (PRESENT) begin : g_bit
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     q <= 1'b0;
                else if (clr_i) q <= 1'b0;
                else if (set_i) q <= 1'b1;
            end
            assign q_o = q;
        end else begin : g_none
            logic unused;
            assign unused = clk ^ rst_n ^ set_i ^ clr_i;
            assign q_o    = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/i2c_cmd_start_fsm.sv
module i2c_cmd_start_fsm
    import i2c_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic start_o
);
    start_st_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (set_i && !clr_i) state_d = ST_PEND;
            ST_PEND: if (clr_i)           state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        start_o = (state_q == ST_PEND);
    end
endmodule

// File: rtl/i2c_cmd_cfg.sv
module i2c_cmd_cfg
    import i2c_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [LANES-1:0] wr_strb,
    input  logic             locked,
    output cfg_t             cfg_o
);
    logic [LANES-1:0] lane_we;
    logic [LANES-1:0] lane_open;
    cfg_t cfg_q;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_we[i] = wr_en && wr_strb[i];
        end
        lane_open = lane_we & {LANES{~locked}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            if (lane_open[0]) cfg_q.addr[7:0] <= wr_data[7:0];
            if (lane_open[1]) begin
                cfg_q.addr[ADDR_W-1:8] <= wr_data[ADDR_W-1:8];
                cfg_q.dir              <= wr_data[POS_DIR];
                cfg_q.a10              <= wr_data[POS_A10];
                cfg_q.hdr              <= wr_data[POS_HDR];
            end
            if (lane_open[2]) cfg_q.cnt <= wr_data[POS_CNT +: CNT_W];
            if (lane_we[3]) begin
                cfg_q.rld  <= wr_data[POS_RLD];
                cfg_q.aend <= wr_data[POS_AEND];
            end
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/i2c_cmd_ctrl_reg.sv
module i2c_cmd_ctrl_reg
    import i2c_cmd_pkg::*;
#(
    parameter bit SMBUS_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              periph_en,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        wr_strb,
    input  logic              ev_addr_done,
    input  logic              ev_arb_lost,
    input  logic              ev_timeout,
    input  logic              ev_addr_clr,
    input  logic              ev_stop_det,
    input  logic              ev_nack_sent,
    input  logic              ev_addr_match,
    input  logic              ev_pec_sent,
    output logic [31:0]       rd_data,
    output logic [9:0]        tgt_addr,
    output logic              dir_rd,
    output logic              addr10,
    output logic              hdr_only,
    output logic [7:0]        nbytes,
    output logic              reload,
    output logic              autoend,
    output logic              start_req,
    output logic              stop_req,
    output logic              nack_req,
    output logic              pec_req
);
    localparam int CMD_LANE_LO = POS_STOP / 8;
    localparam int CMD_LANE_PEC = POS_PEC / 8;

    cfg_t            cfg;
    logic            start_set, start_clr;
    logic [NCMD-1:0] cmd_set, cmd_clr, cmd_q;

    always_comb begin
        start_set = wr_en && wr_strb[POS_START/8] && wr_data[POS_START];
        start_clr = ev_addr_done || ev_arb_lost || ev_timeout || ev_addr_clr || !periph_en;

        cmd_set[CMD_STOP] = wr_en && wr_strb[CMD_LANE_LO]  && wr_data[POS_STOP];
        cmd_set[CMD_NACK] = wr_en && wr_strb[CMD_LANE_LO]  && wr_data[POS_NACK];
        cmd_set[CMD_PEC]  = wr_en && wr_strb[CMD_LANE_PEC] && wr_data[POS_PEC];

        cmd_clr[CMD_STOP] = ev_stop_det || !periph_en;
        cmd_clr[CMD_NACK] = ev_nack_sent || ev_stop_det || ev_addr_match || !periph_en;
        cmd_clr[CMD_PEC]  = ev_pec_sent  || ev_stop_det || ev_addr_match || !periph_en;
    end

    i2c_cmd_start_fsm u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (start_set),
        .clr_i   (start_clr),
        .start_o (start_req)
    );

    i2c_cmd_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_strb (wr_strb),
        .locked  (start_req),
        .cfg_o   (cfg)
    );

    generate
        for (genvar k = 0; k < NCMD; k++) begin : g_cmd
            localparam bit KEEP = (k == CMD_PEC) ? SMBUS_EN : 1'b1;
            i2c_cmd_w1s_bit #(.PRESENT(KEEP)) u_bit (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (cmd_set[k]),
                .clr_i (cmd_clr[k]),
                .q_o   (cmd_q[k])
            );
        end
    endgenerate

    always_comb begin
        tgt_addr = cfg.addr;
        dir_rd   = cfg.dir;
        addr10   = cfg.a10;
        hdr_only = cfg.hdr;
        nbytes   = cfg.cnt;
        reload   = cfg.rld;
        autoend  = cfg.aend;
        stop_req = cmd_q[CMD_STOP];
        nack_req = cmd_q[CMD_NACK];
        pec_req  = cmd_q[CMD_PEC];

        rd_data                      = '0;
        rd_data[ADDR_W-1:0]          = cfg.addr;
        rd_data[POS_DIR]             = cfg.dir;
        rd_data[POS_A10]             = cfg.a10;
        rd_data[POS_HDR]             = cfg.hdr;
        rd_data[POS_START]           = start_req;
        rd_data[POS_STOP]            = cmd_q[CMD_STOP];
        rd_data[POS_NACK]            = cmd_q[CMD_NACK];
        rd_data[POS_CNT +: CNT_W]    = cfg.cnt;
        rd_data[POS_RLD]             = cfg.rld;
        rd_data[POS_AEND]            = cfg.aend;
        rd_data[POS_PEC]             = cmd_q[CMD_PEC];
    end
endmodule

// File: rtl/i2c_cmd_ctrl_chk.sv
module i2c_cmd_ctrl_chk #(
    parameter bit SMBUS_EN = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        periph_en,
    input logic        ev_addr_done,
    input logic        ev_arb_lost,
    input logic        ev_timeout,
    input logic        ev_addr_clr,
    input logic        ev_stop_det,
    input logic        ev_nack_sent,
    input logic        ev_addr_match,
    input logic        ev_pec_sent,
    input logic [31:0] rd_data,
    input logic [9:0]  tgt_addr,
    input logic        dir_rd,
    input logic        addr10,
    input logic        hdr_only,
    input logic [7:0]  nbytes,
    input logic        start_req,
    input logic        stop_req,
    input logic        nack_req,
    input logic        pec_req
);
    // R2
    always_comb begin
        if (rst_n) upper_zero_chk: assert (rd_data[31:27] == 5'b0);
    end

    // R5
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_addr_done || ev_arb_lost || ev_timeout || ev_addr_clr) |=> !start_req);

    // R6
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop_det |=> !stop_req);

    // R7
    nack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_nack_sent || ev_stop_det || ev_addr_match) |=> !nack_req);

    // R8
    pec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pec_sent || ev_stop_det || ev_addr_match) |=> !pec_req);

    // R9
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> !(start_req || stop_req || nack_req || pec_req));

    // R4
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && periph_en && !ev_stop_det) |=> stop_req);

    // R11
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> $stable({tgt_addr, dir_rd, addr10, hdr_only, nbytes}));

    // R12
    pec_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !SMBUS_EN |-> !pec_req);
endmodule

bind i2c_cmd_ctrl_reg i2c_cmd_ctrl_chk #(.SMBUS_EN(SMBUS_EN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .periph_en     (periph_en),
    .ev_addr_done  (ev_addr_done),
    .ev_arb_lost   (ev_arb_lost),
    .ev_timeout    (ev_timeout),
    .ev_addr_clr   (ev_addr_clr),
    .ev_stop_det   (ev_stop_det),
    .ev_nack_sent  (ev_nack_sent),
    .ev_addr_match (ev_addr_match),
    .ev_pec_sent   (ev_pec_sent),
    .rd_data       (rd_data),
    .tgt_addr      (tgt_addr),
    .dir_rd        (dir_rd),
    .addr10        (addr10),
    .hdr_only      (hdr_only),
    .nbytes        (nbytes),
    .start_req     (start_req),
    .stop_req      (stop_req),
    .nack_req      (nack_req),
    .pec_req       (pec_req)
);

// File: tb/tb_i2c_cmd_ctrl_reg.sv
`timescale 1ns/1ps
module tb_i2c_cmd_ctrl_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        periph_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_strb = '0;
    logic [7:0]  ev = '0;
    logic [31:0] rd_a, rd_b;
    logic [9:0]  addr_a, addr_b;
    logic        dir_a, a10_a, hdr_a, rld_a, aend_a, st_a, sp_a, nk_a, pec_a;
    logic        dir_b, a10_b, hdr_b, rld_b, aend_b, st_b, sp_b, nk_b, pec_b;
    logic [7:0]  cnt_a, cnt_b;
    logic [31:0] model = '0;
    int          vectors = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    i2c_cmd_ctrl_reg dut (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .wr_en(wr_en),
        .wr_data(wr_data), .wr_strb(wr_strb),
        .ev_addr_done(ev[0]), .ev_arb_lost(ev[1]), .ev_timeout(ev[2]), .ev_addr_clr(ev[3]),
        .ev_stop_det(ev[4]), .ev_nack_sent(ev[5]), .ev_addr_match(ev[6]), .ev_pec_sent(ev[7]),
        .rd_data(rd_a), .tgt_addr(addr_a), .dir_rd(dir_a), .addr10(a10_a), .hdr_only(hdr_a),
        .nbytes(cnt_a), .reload(rld_a), .autoend(aend_a), .start_req(st_a), .stop_req(sp_a),
        .nack_req(nk_a), .pec_req(pec_a)
    );

    i2c_cmd_ctrl_reg #(.SMBUS_EN(1'b0)) dut_nosmb (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .wr_en(wr_en),
        .wr_data(wr_data), .wr_strb(wr_strb),
        .ev_addr_done(ev[0]), .ev_arb_lost(ev[1]), .ev_timeout(ev[2]), .ev_addr_clr(ev[3]),
        .ev_stop_det(ev[4]), .ev_nack_sent(ev[5]), .ev_addr_match(ev[6]), .ev_pec_sent(ev[7]),
        .rd_data(rd_b), .tgt_addr(addr_b), .dir_rd(dir_b), .addr10(a10_b), .hdr_only(hdr_b),
        .nbytes(cnt_b), .reload(rld_b), .autoend(aend_b), .start_req(st_b), .stop_req(sp_b),
        .nack_req(nk_b), .pec_req(pec_b)
    );

    function automatic logic [31:0] next_model(input logic [31:0] m, input logic we,
            input logic [31:0] d, input logic [3:0] s, input logic p, input logic [7:0] e);
        logic [31:0] r = m;
        logic lk = m[13];
        if (we) begin
            if (s[0] && !lk) r[7:0] = d[7:0];
            if (s[1]) begin
                if (!lk) r[12:8] = d[12:8];
                r[15:13] = r[15:13] | d[15:13];
            end
            if (s[2] && !lk) r[23:16] = d[23:16];
            if (s[3]) begin
                r[25:24] = d[25:24];
                r[26] = r[26] | d[26];
            end
        end
        if (|e[3:0] || !p)                 r[13] = 1'b0;
        if (e[4] || !p)                    r[14] = 1'b0;
        if (e[5] || e[4] || e[6] || !p)    r[15] = 1'b0;
        if (e[7] || e[4] || e[6] || !p)    r[26] = 1'b0;
        r[31:27] = 5'b0;
        return r;
    endfunction

    task automatic compare(input string tag);
        logic [31:0] fa, fb, eb;
        fa = {5'b0, pec_a, aend_a, rld_a, cnt_a, nk_a, sp_a, st_a, hdr_a, a10_a, dir_a, addr_a};
        fb = {5'b0, pec_b, aend_b, rld_b, cnt_b, nk_b, sp_b, st_b, hdr_b, a10_b, dir_b, addr_b};
        eb = model & ~32'h0400_0000;
        vectors++;
        if (rd_a !== model || fa !== model) begin
            fails++;
            $display("FAIL %s: rd=%h fields=%h expected=%h", tag, rd_a, fa, model);
        end
        vectors++;
        if (rd_b !== eb || fb !== eb) begin
            fails++;
            $display("FAIL R12 (%s): rd=%h fields=%h expected=%h", tag, rd_b, fb, eb);
        end
    endtask

    task automatic step(input logic we, input logic [31:0] d, input logic [3:0] s,
                        input logic p, input logic [7:0] e, input string tag);
        wr_en = we; wr_data = d; wr_strb = s; periph_en = p; ev = e;
        model = next_model(model, we, d, s, p, e);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; ev = '0;
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] x;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");
        step(1, 32'hFFFF_DFFF, 4'hF, 1, 8'h00, "R2 R13 full write");
        step(1, 32'h0000_0000, 4'hF, 1, 8'h00, "R4 zero write");
        step(1, 32'h1234_56AA, 4'h1, 1, 8'h00, "R3 lane0 only");
        step(1, 32'h5A5A_5A5A, 4'h4, 1, 8'h00, "R3 lane2 only");
        step(0, 32'h0000_0000, 4'h0, 1, 8'h10, "R6 stop detect");
        step(1, 32'h0400_8000, 4'hA, 1, 8'h00, "R4 set nack pec");
        step(0, 32'h0, 4'h0, 1, 8'h20, "R7 nack sent");
        step(0, 32'h0, 4'h0, 1, 8'h80, "R8 pec sent");
        step(1, 32'h0400_8000, 4'hA, 1, 8'h40, "R10 set vs addr match");
        step(1, 32'h0400_8000, 4'hA, 1, 8'h00, "R4 set nack pec again");
        step(0, 32'h0, 4'h0, 1, 8'h40, "R7 R8 addr match");
        step(1, 32'h0000_2000, 4'h2, 1, 8'h04, "R10 start vs timeout");
        step(1, 32'h00C3_2155, 4'h7, 1, 8'h00, "R5 set start with cfg");
        step(1, 32'hFFFF_DFFF, 4'hF, 1, 8'h00, "R11 locked write");
        step(0, 32'h0, 4'h0, 1, 8'h08, "R5 addr flag clear");
        step(1, 32'h0000_2000, 4'h2, 1, 8'h00, "R5 set start");
        step(0, 32'h0, 4'h0, 1, 8'h02, "R5 arbitration lost");
        step(1, 32'h0000_2000, 4'h2, 1, 8'h00, "R5 set start");
        step(0, 32'h0, 4'h0, 1, 8'h01, "R5 address done");
        step(1, 32'h0400_E000, 4'hA, 1, 8'h00, "R4 set all commands");
        step(0, 32'h0, 4'h0, 0, 8'h00, "R9 disable clears");
        step(1, 32'h0400_E000, 4'hA, 0, 8'h00, "R9 set while disabled");
        x = 32'h1BAD_F00D;
        for (int i = 0; i < 6000; i++) begin
            logic [31:0] d;
            logic [7:0]  e;
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            d = x;
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            for (int k = 0; k < 8; k++) e[k] = &x[10+3*k +: 3];
            step(x[0] | x[1], d, x[5:2], |x[9:6], e, "R3 R4 R11 sweep");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule